// File: doc/BRIEF.md
# Partitioned SIMD Equality Comparator

This block compares two 64-bit operands for equality. A 7-bit cut vector, chosen at runtime, splits the operands into independent lanes. The operands are handled as eight 8-bit chunks, and cut bit i separates chunk i from chunk i+1. Each lane is a run of adjacent chunks with no cut between them. The lane's result is true only when the two operands match over every bit the lane covers.

The result is reported as one bit per chunk, and every chunk of a lane carries that lane's single result. The same datapath can therefore serve as one 64-bit compare, as eight 8-bit compares, or as any mix of lane widths in between.

The block is purely combinational and has no clock or reset. Its output follows its inputs within the same cycle, so it can sit directly in a SIMD execution stage.

Top module: `pcmp_eq_top`

## Requirements
- R1: Chunk k covers operand bits [k*8+7 : k*8], and result bit k (`chunk_match[k]`) belongs to chunk k.
- R2: Cut bit i (`lane_cut[i]`), when 1, places a lane boundary between chunk i and chunk i+1, that is, at operand bit (i+1)*8. When 0, the two chunks belong to the same lane.
- R3: A lane starting at chunk p and spanning w chunks reports 1 exactly when `op_a` and `op_b` are equal over bits p*8 up to (p+w)*8-1.
- R4: All result bits of one lane carry the same value.
- R5: With `lane_cut` all zeros, all eight result bits equal the full 64-bit equality of the operands.
- R6: With `lane_cut` all ones, each result bit is the equality of its own 8-bit chunk.
- R7: Every lane width from 1 to 8 chunks, placed at every starting chunk where it fits, gives the result of R3.
- R8: A difference in a single bit clears every result bit of the lane holding that bit and no result bit of any other lane.
- R9: The output is a combinational function of the present inputs, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| lane_cut | input | 7 | Cut vector; bit i set ends a lane above chunk i |
| chunk_match | output | 8 | Per-chunk copy of its lane's equality result |

## Verification
The bench builds the block with its default parameters: 8-bit chunks and eight of them. At this size all 36 lane placements can be swept exhaustively, each once with equal operands and once with a single bit flipped inside the lane. Random cut vectors are mixed with operands that are mostly equal chunk by chunk. As a result, true lane results appear about as often as false ones, and mismatches reach both narrow and wide lanes.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

  // Lowest operand bit index of a given chunk
  function automatic int span_lsb(input int chunk, input int chunk_w);
    return chunk * chunk_w;
  endfunction

  // Number of cut bits needed for a given chunk count
  function automatic int cut_count(input int chunks);
    return (chunks > 1) ? chunks - 1 : 1;
  endfunction

endpackage

// File: rtl/pcmp_chunk_eq.sv
module pcmp_chunk_eq #(
  parameter int CHUNK_W    = 8,
  parameter int NUM_CHUNKS = 8
) (
  input  logic [CHUNK_W*NUM_CHUNKS-1:0] a_i,
  input  logic [CHUNK_W*NUM_CHUNKS-1:0] b_i,
  output logic [NUM_CHUNKS-1:0]         eq_o
);

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
    localparam int LSB = pcmp_pkg::span_lsb(g, CHUNK_W);
    assign eq_o[g] = (a_i[LSB +: CHUNK_W] == b_i[LSB +: CHUNK_W]); // R1
  end

endmodule

// File: rtl/pcmp_run_scan.sv
module pcmp_run_scan #(
  parameter int NUM_CHUNKS = 8,
  localparam int CUT_W = pcmp_pkg::cut_count(NUM_CHUNKS)
) (
  input  logic [NUM_CHUNKS-1:0] chunk_eq_i,
  input  logic [CUT_W-1:0]      cut_i,
  output logic [NUM_CHUNKS-1:0] run_o
);

  // run_o[k] holds the AND of chunk equalities from the lane start up to chunk k
  always_comb begin
    logic acc;
    acc = 1'b1;
    for (int k = 0; k < NUM_CHUNKS; k++) begin
      if (k > 0 && cut_i[k-1]) acc = 1'b1;   // R2: a new lane restarts the run
      acc = acc & chunk_eq_i[k];
      run_o[k] = acc;
    end
  end

endmodule

// File: rtl/pcmp_lane_spread.sv
module pcmp_lane_spread #(
  parameter int NUM_CHUNKS = 8,
  localparam int CUT_W = pcmp_pkg::cut_count(NUM_CHUNKS)
) (
  input  logic [NUM_CHUNKS-1:0] run_i,
  input  logic [NUM_CHUNKS-1:0] chunk_eq_i,
  input  logic [CUT_W-1:0]      cut_i,
  output logic [NUM_CHUNKS-1:0] res_o
);

  // The lane's top chunk holds the complete AND; copy it down to the lane start
  always_comb begin
    logic acc;
    logic [NUM_CHUNKS-1:0] r;
    acc = run_i[NUM_CHUNKS-1];
    r[NUM_CHUNKS-1] = acc;
    for (int k = NUM_CHUNKS - 2; k >= 0; k--) begin
      if (cut_i[k]) acc = run_i[k];
      r[k] = acc;
    end
    res_o = r;

    for (int k = 0; k < NUM_CHUNKS - 1; k++) begin
      if (!cut_i[k])
        AST_LANE_UNIFORM: assert (r[k] == r[k+1]); // R4
    end
    for (int k = 0; k < NUM_CHUNKS; k++) begin
      if (!chunk_eq_i[k])
        AST_MISMATCH_CLEARS: assert (!r[k]); // R8
    end
    if (&cut_i)
      AST_FULL_SPLIT: assert (r == chunk_eq_i); // R6
    if (cut_i == '0)
      AST_SINGLE_LANE: assert (r == {NUM_CHUNKS{&chunk_eq_i}}); // R5
  end

endmodule

// File: rtl/pcmp_eq_top.sv
module pcmp_eq_top #(
  parameter int CHUNK_W    = 8,
  parameter int NUM_CHUNKS = 8
) (
  input  logic [CHUNK_W*NUM_CHUNKS-1:0]               op_a,
  input  logic [CHUNK_W*NUM_CHUNKS-1:0]               op_b,
  input  logic [pcmp_pkg::cut_count(NUM_CHUNKS)-1:0]  lane_cut,
  output logic [NUM_CHUNKS-1:0]                       chunk_match
);

  logic [NUM_CHUNKS-1:0] chunk_eq;
  logic [NUM_CHUNKS-1:0] run_and;

  pcmp_chunk_eq #(.CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS)) u_chunk_eq (
    .a_i  (op_a),
    .b_i  (op_b),
    .eq_o (chunk_eq)
  );

  pcmp_run_scan #(.NUM_CHUNKS(NUM_CHUNKS)) u_run_scan (
    .chunk_eq_i (chunk_eq),
    .cut_i      (lane_cut),
    .run_o      (run_and)
  );

  // R3, R9: purely combinational result per lane
  pcmp_lane_spread #(.NUM_CHUNKS(NUM_CHUNKS)) u_lane_spread (
    .run_i      (run_and),
    .chunk_eq_i (chunk_eq),
    .cut_i      (lane_cut),
    .res_o      (chunk_match)
  );

endmodule

// File: tb/pcmp_eq_top_tb.sv
module pcmp_eq_top_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [63:0] op_a, op_b;
  logic [6:0]  lane_cut;
  logic [7:0]  chunk_match;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  pcmp_eq_top u_dut (
    .op_a        (op_a),
    .op_b        (op_b),
    .lane_cut    (lane_cut),
    .chunk_match (chunk_match)
  );

  // Reference: locate each chunk's lane bounds, then compare bit by bit
  function automatic logic [7:0] ref_match(input logic [63:0] a, input logic [63:0] b,
                                           input logic [6:0] cut);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) begin
      int lo, hi;
      logic same;
      lo = k;
      while (lo > 0 && !cut[lo-1]) lo--;
      hi = k;
      while (hi < 7 && !cut[hi]) hi++;
      same = 1'b1;
      for (int j = lo * 8; j < hi * 8 + 8; j++)
        if (a[j] != b[j]) same = 1'b0;
      r[k] = same;
    end
    return r;
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic [6:0] cut, input string req);
    logic [7:0] exp;
    @(negedge clk);
    op_a = a; op_b = b; lane_cut = cut;
    #1;
    exp = ref_match(a, b, cut);
    n_checks++;
    if (chunk_match !== exp) begin
      n_fail++;
      $display("FAIL %s: cut=%b actual=%b expected=%b", req, cut, chunk_match, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    logic [6:0]  cut;
    void'($urandom(32'd20240611));

    // Idle inputs: zero operands are equal, R9 combinational output
    apply(64'd0, 64'd0, 7'd0, "R9");
    // R5: single 64-bit lane
    apply(64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 7'd0, "R5");
    apply(64'h0123_4567_89AB_CDEF, 64'h8123_4567_89AB_CDEF, 7'd0, "R5");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 7'd0, "R5");
    // R6 / R1: eight byte lanes, chunk 2 and 7 differ
    apply(64'hAA00_0000_0000_0000, 64'h5500_0000_0000_0000, 7'h7F, "R6");
    apply(64'h0000_0000_0010_0000, 64'h0000_0000_0000_0000, 7'h7F, "R1");
    // R2: cut at bit 32 only; high half differs
    apply(64'h1111_1111_2222_2222, 64'h1111_1112_2222_2222, 7'b0001000, "R2");
    // R4: two lanes of 3 and 5 chunks
    apply(64'h0, 64'h0000_0000_0001_0000, 7'b0000100, "R4");

    // R7 / R8 / R3: every lane placement, equal and single-bit-flipped
    for (int p = 0; p < 8; p++) begin
      for (int w = 1; p + w <= 8; w++) begin
        for (int flip = 0; flip < 2; flip++) begin
          cut = 7'($urandom);
          if (p > 0) cut[p-1] = 1'b1;
          for (int j = p; j < p + w - 1; j++) cut[j] = 1'b0;
          if (p + w < 8) cut[p+w-1] = 1'b1;
          a = {$urandom, $urandom};
          b = a;
          if (flip == 1) b[p*8 + int'($urandom % (w * 8))] ^= 1'b1;
          apply(a, b, cut, flip ? "R8" : "R7");
        end
      end
    end

    // R3: random cuts, operands mostly equal per chunk
    for (int n = 0; n < 1500; n++) begin
      a = {$urandom, $urandom};
      b = a;
      for (int k = 0; k < 8; k++)
        if ($urandom % 5 == 0) b[k*8 + int'($urandom % 8)] ^= 1'b1;
      apply(a, b, 7'($urandom), "R3");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule